// File: doc/BRIEF.md
# Blocking L1 Permission Controller

This block is the per-core front end of a small private cache that serves a core's loads and stores under sequential consistency. The core hands it one operation at a time through a valid/ready handshake. The controller takes no new operation until the current one has completed. Each of the 16 direct-mapped blocks holds a single word, a tag and a coherence permission: Invalid, Shared or Modified. Whether an access hits depends on that permission as well as on the tag. A load needs Shared or Modified. A store needs Modified.

When the permission is not sufficient, the controller raises a read-permission request (GetS) or a write-permission request (GetM) towards an abstract coherence port. It holds that request until the grant arrives, installs the granted state, and then completes the operation. If the block it is about to replace holds Modified data, that data leaves as a writeback on the same request. The coherence side can also send an invalidate or a downgrade for any address. The controller applies it at once and acknowledges it one cycle later with the block's word. Several controllers can each complete hits in the same cycle, with no shared ordering point between them.

Top module: `l1_perm_ctrl`

## Requirements
- R1: After reset every block is Invalid, core_ready is high, and core_done, coh_req_valid and snp_ack are low. The first access to any address therefore raises a request.
- R2: A load whose tag matches a block held in Shared or Modified completes without a coherence request. core_done pulses in the cycle after acceptance, and core_rdata carries the stored word.
- R3: A store hits only when the matching block is held in Modified. It then completes in the cycle after acceptance without a request and updates the word.
- R4: A load that finds no matching valid block raises a request with coh_req_kind = 0 (GetS). On the grant the block is installed as Shared with coh_gnt_data, and that word is returned.
- R5: A store to a block that is not held in Modified (Invalid, Shared, or a different tag) raises a request with coh_req_kind = 1 (GetM). On the grant the block is installed as Modified holding the store data.
- R6: The block is strictly blocking. core_ready stays low from acceptance until after the single-cycle core_done pulse. coh_req_valid and its address stay steady until coh_gnt, and no second request is raised.
- R7: An invalidate (snp_kind = 0) to a matching tag makes the block Invalid. snp_ack pulses in the cycle after snp_valid, and snp_data carries the block's word.
- R8: A downgrade (snp_kind = 1) to a matching block moves Modified to Shared and is acknowledged with data in the same way. Later loads still hit, and a later store needs GetM.
- R9: A snoop whose tag does not match the resident block changes nothing, but it is still acknowledged in the next cycle.
- R10: A miss that replaces a Modified block of another tag raises coh_wb_valid together with the request, with the victim's address ({tag, index}, index in the low 4 address bits) and its word. Replacing a Shared block raises no writeback.
- R11: core_ready is low in any cycle in which snp_valid is high, so a snoop is never applied in the same edge as an accepted access.
- R12: Two controllers behind a single-owner directory model keep values coherent. Every load returns the most recent store to that address, and a GetM removes the other core's copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_valid | input | 1 | Core presents an operation |
| core_ready | output | 1 | Controller accepts the operation this cycle |
| core_addr | input | ADDR_W | Word address; low IDX_W bits select the block |
| core_we | input | 1 | 1 = store, 0 = load |
| core_wdata | input | WORD_W | Store data |
| core_done | output | 1 | One-cycle completion pulse |
| core_rdata | output | WORD_W | Word after the operation, valid with core_done |
| coh_req_valid | output | 1 | Permission request outstanding |
| coh_req_kind | output | 1 | 0 = GetS, 1 = GetM |
| coh_req_addr | output | ADDR_W | Requested address |
| coh_wb_valid | output | 1 | Dirty victim carried with the request |
| coh_wb_addr | output | ADDR_W | Victim address |
| coh_wb_data | output | WORD_W | Victim word |
| coh_gnt | input | 1 | Grant of the outstanding request |
| coh_gnt_data | input | WORD_W | Granted word |
| snp_valid | input | 1 | Incoming snoop |
| snp_kind | input | 1 | 0 = invalidate, 1 = downgrade |
| snp_addr | input | ADDR_W | Snooped address |
| snp_ack | output | 1 | Snoop acknowledge, one cycle after snp_valid |
| snp_data | output | WORD_W | Word held at the snooped index |

## Verification
The bench goes after the permission miss: a store to a Shared block. A controller that trusted the tag alone would finish that store locally, and the other core would then read a stale word. Downgrades and invalidates are checked by the accesses that follow them. A load after a downgrade must still hit, and a store after it must ask for GetM. A controller that cleared the block, or left it writable, shows up in the request count. Replacements are checked for a dirty writeback with the right address and word, and for no writeback when the victim was clean. Dropping the victim makes a later reload return old data. A snoop with a foreign tag must leave the resident line alone. A slow grant must keep the core stalled.

// File: rtl/l1pc_pkg.sv
// Shared types for the blocking L1 permission controller.
// Assumes a two-bit permission code and a three-state sequencer.
package l1pc_pkg;
    typedef enum logic [1:0] {
        PERM_I = 2'd0,
        PERM_S = 2'd1,
        PERM_M = 2'd2
    } perm_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MISS = 2'd1,
        ST_DONE = 2'd2
    } seq_e;

    localparam logic REQ_GETS = 1'b0;
    localparam logic REQ_GETM = 1'b1;
    localparam logic SNP_INV  = 1'b0;
    localparam logic SNP_DOWN = 1'b1;
endpackage

// File: rtl/l1pc_array.sv
// Direct-mapped storage of tag, permission and one word per block.
// Two combinational read ports: one for the core path, one for snoops.
// Update priority per block: grant install, then snoop, then store hit.
// Assumes the sequencer never drives a store hit in a snoop cycle.
module l1pc_array
    import l1pc_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 2,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    output perm_e             lk_perm,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [WORD_W-1:0] lk_data,
    input  logic [IDX_W-1:0]  sn_idx,
    output logic [WORD_W-1:0] sn_data,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              ins_en,
    input  logic [TAG_W-1:0]  ins_tag,
    input  perm_e             ins_perm,
    input  logic [WORD_W-1:0] ins_data,
    input  logic              snp_en,
    input  logic [TAG_W-1:0]  snp_tag,
    input  logic              snp_kind
);
    localparam int NBLK = 1 << IDX_W;

    perm_e             perm_v [NBLK];
    logic [TAG_W-1:0]  tag_v  [NBLK];
    logic [WORD_W-1:0] data_v [NBLK];

    for (genvar i = 0; i < NBLK; i++) begin : g_blk
        perm_e             perm_q;
        logic [TAG_W-1:0]  tag_q;
        logic [WORD_W-1:0] data_q;
        logic              sel_lk;
        logic              sel_sn;

        assign sel_lk = (lk_idx == IDX_W'(i));
        assign sel_sn = snp_en && (sn_idx == IDX_W'(i)) && (tag_q == snp_tag);

        // Per-block state update with install > snoop > store-hit priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                perm_q <= PERM_I;
                tag_q  <= '0;
                data_q <= '0;
            end else if (ins_en && sel_lk) begin
                perm_q <= ins_perm;
                tag_q  <= ins_tag;
                data_q <= ins_data;
            end else if (sel_sn) begin
                if (snp_kind == SNP_INV) begin
                    perm_q <= PERM_I;
                end else if (perm_q == PERM_M) begin
                    perm_q <= PERM_S;
                end
            end else if (wr_en && sel_lk) begin
                data_q <= wr_data;
            end
        end

        assign perm_v[i] = perm_q;
        assign tag_v[i]  = tag_q;
        assign data_v[i] = data_q;
    end

    assign lk_perm = perm_v[lk_idx];
    assign lk_tag  = tag_v[lk_idx];
    assign lk_data = data_v[lk_idx];
    assign sn_data = data_v[sn_idx];
endmodule

// File: rtl/l1pc_lookup.sv
// Permission-based hit decision for the operation on the core path.
// A load hits on Shared or Modified, a store only on Modified; a Modified
// block of another tag is a dirty victim.
module l1pc_lookup
    import l1pc_pkg::*;
#(
    parameter int TAG_W = 2
) (
    input  logic             op_we,
    input  logic [TAG_W-1:0] op_tag,
    input  perm_e            blk_perm,
    input  logic [TAG_W-1:0] blk_tag,
    output logic             hit,
    output logic             victim_dirty
);
    logic tag_eq;

    // Combine tag match with the permission the operation needs.
    always_comb begin
        tag_eq       = (blk_tag == op_tag);
        hit          = tag_eq && (op_we ? (blk_perm == PERM_M) : (blk_perm != PERM_I));
        victim_dirty = !tag_eq && (blk_perm == PERM_M);
    end
endmodule

// File: rtl/l1pc_seq.sv
// Blocking sequencer: accepts one operation, completes a hit in one cycle,
// or holds a permission request until its grant, then pulses done.
// Assumes the coherence side grants only while a request is outstanding.
module l1pc_seq
    import l1pc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_valid,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic              core_we,
    input  logic [WORD_W-1:0] core_wdata,
    input  logic              snp_valid,
    input  logic              hit,
    input  logic [WORD_W-1:0] blk_data,
    input  logic              coh_gnt,
    input  logic [WORD_W-1:0] coh_gnt_data,
    output logic              core_ready,
    output logic              core_done,
    output logic [WORD_W-1:0] core_rdata,
    output logic              miss_busy,
    output logic [ADDR_W-1:0] op_addr,
    output logic              op_we,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data,
    output logic              ins_en,
    output perm_e             ins_perm,
    output logic [WORD_W-1:0] ins_data
);
    seq_e              st_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic              pend_we_q;
    logic [WORD_W-1:0] pend_wdata_q;
    logic [WORD_W-1:0] rdata_q;
    logic              accept;

    // Handshake, operand selection and array update strobes.
    always_comb begin
        core_ready = (st_q == ST_IDLE) && !snp_valid;
        accept     = core_valid && core_ready;
        op_addr    = (st_q == ST_IDLE) ? core_addr : pend_addr_q;
        op_we      = (st_q == ST_IDLE) ? core_we   : pend_we_q;
        wr_en      = accept && hit && core_we;
        wr_data    = core_wdata;
        ins_en     = (st_q == ST_MISS) && coh_gnt;
        ins_perm   = pend_we_q ? PERM_M : PERM_S;
        ins_data   = pend_we_q ? pend_wdata_q : coh_gnt_data;
        miss_busy  = (st_q == ST_MISS);
        core_done  = (st_q == ST_DONE);
        core_rdata = rdata_q;
    end

    // State, pending operation and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_IDLE;
            pend_addr_q  <= '0;
            pend_we_q    <= 1'b0;
            pend_wdata_q <= '0;
            rdata_q      <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        pend_addr_q  <= core_addr;
                        pend_we_q    <= core_we;
                        pend_wdata_q <= core_wdata;
                        if (hit) begin
                            rdata_q <= core_we ? core_wdata : blk_data;
                            st_q    <= ST_DONE;
                        end else begin
                            st_q    <= ST_MISS;
                        end
                    end
                end
                ST_MISS: begin
                    if (coh_gnt) begin
                        rdata_q <= ins_data;
                        st_q    <= ST_DONE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/l1_perm_ctrl.sv
// Top of the blocking L1 permission controller: wires the sequencer,
// the hit decision and the block array, drives the coherence request
// and writeback, and acknowledges snoops one cycle after they arrive.
// Assumes at most one snoop per cycle and no snoop in a grant cycle.
module l1_perm_ctrl
    import l1pc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_valid,
    output logic              core_ready,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic              core_we,
    input  logic [WORD_W-1:0] core_wdata,
    output logic              core_done,
    output logic [WORD_W-1:0] core_rdata,
    output logic              coh_req_valid,
    output logic              coh_req_kind,
    output logic [ADDR_W-1:0] coh_req_addr,
    output logic              coh_wb_valid,
    output logic [ADDR_W-1:0] coh_wb_addr,
    output logic [WORD_W-1:0] coh_wb_data,
    input  logic              coh_gnt,
    input  logic [WORD_W-1:0] coh_gnt_data,
    input  logic              snp_valid,
    input  logic              snp_kind,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_ack,
    output logic [WORD_W-1:0] snp_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [ADDR_W-1:0] op_addr;
    logic              op_we;
    perm_e             lk_perm;
    logic [TAG_W-1:0]  lk_tag;
    logic [WORD_W-1:0] lk_data;
    logic [WORD_W-1:0] sn_data;
    logic              hit;
    logic              victim_dirty;
    logic              miss_busy;
    logic              wr_en;
    logic [WORD_W-1:0] wr_data;
    logic              ins_en;
    perm_e             ins_perm;
    logic [WORD_W-1:0] ins_data;
    logic              ack_q;
    logic [WORD_W-1:0] ack_data_q;

    l1pc_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .core_valid   (core_valid),
        .core_addr    (core_addr),
        .core_we      (core_we),
        .core_wdata   (core_wdata),
        .snp_valid    (snp_valid),
        .hit          (hit),
        .blk_data     (lk_data),
        .coh_gnt      (coh_gnt),
        .coh_gnt_data (coh_gnt_data),
        .core_ready   (core_ready),
        .core_done    (core_done),
        .core_rdata   (core_rdata),
        .miss_busy    (miss_busy),
        .op_addr      (op_addr),
        .op_we        (op_we),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .ins_en       (ins_en),
        .ins_perm     (ins_perm),
        .ins_data     (ins_data)
    );

    l1pc_lookup #(.TAG_W(TAG_W)) u_lookup (
        .op_we        (op_we),
        .op_tag       (op_addr[ADDR_W-1:IDX_W]),
        .blk_perm     (lk_perm),
        .blk_tag      (lk_tag),
        .hit          (hit),
        .victim_dirty (victim_dirty)
    );

    l1pc_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .WORD_W(WORD_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (op_addr[IDX_W-1:0]),
        .lk_perm  (lk_perm),
        .lk_tag   (lk_tag),
        .lk_data  (lk_data),
        .sn_idx   (snp_addr[IDX_W-1:0]),
        .sn_data  (sn_data),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ins_en   (ins_en),
        .ins_tag  (op_addr[ADDR_W-1:IDX_W]),
        .ins_perm (ins_perm),
        .ins_data (ins_data),
        .snp_en   (snp_valid),
        .snp_tag  (snp_addr[ADDR_W-1:IDX_W]),
        .snp_kind (snp_kind)
    );

    // Request and dirty-victim writeback driven from the pending operation.
    always_comb begin
        coh_req_valid = miss_busy;
        coh_req_kind  = op_we ? REQ_GETM : REQ_GETS;
        coh_req_addr  = op_addr;
        coh_wb_valid  = miss_busy && victim_dirty;
        coh_wb_addr   = {lk_tag, op_addr[IDX_W-1:0]};
        coh_wb_data   = lk_data;
    end

    // Snoop acknowledge with the word captured when the snoop arrived.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q      <= 1'b0;
            ack_data_q <= '0;
        end else begin
            ack_q <= snp_valid;
            if (snp_valid) begin
                ack_data_q <= sn_data;
            end
        end
    end

    assign snp_ack  = ack_q;
    assign snp_data = ack_data_q;
endmodule

// File: rtl/l1pc_checker.sv
// Protocol checker for the controller's ports, bound to every instance.
// Assumes the coherence side raises coh_gnt only while a request is held.
module l1pc_checker #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_ready,
    input logic              core_done,
    input logic              coh_req_valid,
    input logic [ADDR_W-1:0] coh_req_addr,
    input logic              coh_req_kind,
    input logic              coh_wb_valid,
    input logic              coh_gnt,
    input logic              snp_valid,
    input logic              snp_ack
);
    p_done_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |-> !core_ready);

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> !core_done);

    p_req_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        coh_req_valid |-> !core_ready);

    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (coh_req_valid && !coh_gnt) |=>
            (coh_req_valid && $stable(coh_req_addr) && $stable(coh_req_kind)));

    p_gnt_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (coh_req_valid && coh_gnt) |=> (core_done && !coh_req_valid));

    p_snoop_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |=> snp_ack);

    p_ack_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snp_ack |-> $past(snp_valid));

    p_snoop_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !core_ready);

    p_wb_with_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        coh_wb_valid |-> coh_req_valid);
endmodule

bind l1_perm_ctrl l1pc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .core_ready    (core_ready),
    .core_done     (core_done),
    .coh_req_valid (coh_req_valid),
    .coh_req_addr  (coh_req_addr),
    .coh_req_kind  (coh_req_kind),
    .coh_wb_valid  (coh_wb_valid),
    .coh_gnt       (coh_gnt),
    .snp_valid     (snp_valid),
    .snp_ack       (snp_ack)
);

// File: tb/sim_l1_perm_ctrl.sv
// Two controllers behind a single-owner directory model with a golden memory.
module sim_l1_perm_ctrl;
    localparam int CLK_P = 10;
    localparam int NA    = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic        cv[2], cr[2], cwe[2], cdone[2];
    logic [5:0]  ca[2];
    logic [31:0] cwd[2], crd[2];
    logic        qv[2], qk[2], wbv[2], gnt[2];
    logic [5:0]  qa[2], wba[2];
    logic [31:0] wbd[2], gd[2];
    logic        sv[2], sk[2], sack[2];
    logic [5:0]  sa[2];
    logic [31:0] sd[2];

    int vectors = 0;
    int fails   = 0;
    bit finished = 0;

    logic [31:0] gold [NA];
    logic [31:0] mem  [NA];
    int          owner[NA];
    logic [1:0]  shr  [NA];
    int          req_cnt[2];
    logic        last_kind[2];
    logic        last_wbv[2];
    logic [5:0]  last_wba[2];
    logic [31:0] last_wbd[2];
    int          gnt_delay = 0;

    l1_perm_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .core_valid(cv[0]), .core_ready(cr[0]),
        .core_addr(ca[0]), .core_we(cwe[0]), .core_wdata(cwd[0]),
        .core_done(cdone[0]), .core_rdata(crd[0]), .coh_req_valid(qv[0]),
        .coh_req_kind(qk[0]), .coh_req_addr(qa[0]), .coh_wb_valid(wbv[0]),
        .coh_wb_addr(wba[0]), .coh_wb_data(wbd[0]), .coh_gnt(gnt[0]),
        .coh_gnt_data(gd[0]), .snp_valid(sv[0]), .snp_kind(sk[0]),
        .snp_addr(sa[0]), .snp_ack(sack[0]), .snp_data(sd[0])
    );

    l1_perm_ctrl u1 (
        .clk(clk), .rst_n(rst_n), .core_valid(cv[1]), .core_ready(cr[1]),
        .core_addr(ca[1]), .core_we(cwe[1]), .core_wdata(cwd[1]),
        .core_done(cdone[1]), .core_rdata(crd[1]), .coh_req_valid(qv[1]),
        .coh_req_kind(qk[1]), .coh_req_addr(qa[1]), .coh_wb_valid(wbv[1]),
        .coh_wb_addr(wba[1]), .coh_wb_data(wbd[1]), .coh_gnt(gnt[1]),
        .coh_gnt_data(gd[1]), .snp_valid(sv[1]), .snp_kind(sk[1]),
        .snp_addr(sa[1]), .snp_ack(sack[1]), .snp_data(sd[1])
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Snoop one controller; the ack and ready timing are checked here.
    task automatic snoop(input int o, input logic k, input int a, output logic [31:0] d);
        @(negedge clk);
        sv[o] = 1'b1; sk[o] = k; sa[o] = a[5:0];
        #2;
        chk(cr[o] == 1'b0, "R11", "ready during snoop", 32'(cr[o]), 32'd0);
        @(negedge clk);
        sv[o] = 1'b0;
        #2;
        chk(sack[o] == 1'b1, "R7", "ack one cycle after snoop", 32'(sack[o]), 32'd1);
        d = sd[o];
    endtask

    // Directory service of one request (single owner or many sharers).
    task automatic service(input int c);
        int o, a;
        logic [31:0] d;
        o = 1 - c;
        a = int'(qa[c]);
        req_cnt[c]++;
        last_kind[c] = qk[c];
        last_wbv[c]  = wbv[c];
        last_wba[c]  = wba[c];
        last_wbd[c]  = wbd[c];
        if (wbv[c]) begin
            mem[wba[c]] = wbd[c];
            if (owner[wba[c]] == c) owner[wba[c]] = -1;
            shr[wba[c]][c] = 1'b0;
        end
        if (qk[c] == 1'b0) begin
            if (owner[a] == o) begin
                snoop(o, 1'b1, a, d);
                mem[a] = d; owner[a] = -1; shr[a][o] = 1'b1;
            end
            shr[a][c] = 1'b1;
        end else begin
            if (owner[a] == o) begin
                snoop(o, 1'b0, a, d);
                mem[a] = d;
            end else if (shr[a][o]) begin
                snoop(o, 1'b0, a, d);
            end
            owner[a] = c; shr[a] = 2'b00;
        end
        repeat (gnt_delay) @(negedge clk);
        @(negedge clk);
        gnt[c] = 1'b1; gd[c] = mem[a];
        @(negedge clk);
        gnt[c] = 1'b0;
    endtask

    initial begin
        wait (rst_n);
        forever begin
            @(negedge clk);
            #3;
            if (qv[0]) service(0);
            else if (qv[1]) service(1);
        end
    end

    task automatic do_op(input int c, input int a, input bit we, input logic [31:0] wd,
                         output logic [31:0] rd, output int lat, output int nreq);
        int r0;
        bit rdy_bad;
        r0 = req_cnt[c];
        rdy_bad = 0;
        @(negedge clk);
        cv[c] = 1'b1; ca[c] = a[5:0]; cwe[c] = we; cwd[c] = wd;
        forever begin
            #2;
            if (cr[c]) break;
            @(negedge clk);
        end
        @(negedge clk);
        cv[c] = 1'b0;
        lat = 0;
        forever begin
            #2;
            if (cdone[c]) break;
            if (cr[c]) rdy_bad = 1;
            lat++;
            @(negedge clk);
        end
        rd = crd[c];
        nreq = req_cnt[c] - r0;
        chk(!rdy_bad, "R6", "ready low while busy", 32'(rdy_bad), 32'd0);
        if (we) gold[a] = wd;
    endtask

    task automatic ld(input int c, input int a, input int exp_req, input string rq);
        logic [31:0] rd;
        int lat, n;
        do_op(c, a, 1'b0, 32'd0, rd, lat, n);
        chk(rd == gold[a], rq, $sformatf("core%0d load %0d data", c, a), rd, gold[a]);
        chk(n == exp_req, rq, $sformatf("core%0d load %0d requests", c, a), 32'(n), 32'(exp_req));
        if (exp_req == 0)
            chk(lat == 0, "R2", "load hit latency", 32'(lat), 32'd0);
        else
            chk(last_kind[c] == 1'b0, "R4", "load miss kind GetS", 32'(last_kind[c]), 32'd0);
    endtask

    task automatic st(input int c, input int a, input logic [31:0] wd, input int exp_req,
                      input string rq);
        logic [31:0] rd;
        int lat, n;
        do_op(c, a, 1'b1, wd, rd, lat, n);
        chk(rd == wd, rq, "store result word", rd, wd);
        chk(n == exp_req, rq, $sformatf("core%0d store %0d requests", c, a), 32'(n), 32'(exp_req));
        if (exp_req == 0)
            chk(lat == 0, "R3", "store hit latency", 32'(lat), 32'd0);
        else
            chk(last_kind[c] == 1'b1, "R5", "store miss kind GetM", 32'(last_kind[c]), 32'd1);
    endtask

    initial begin
        logic [31:0] d;
        logic [31:0] rd;
        int lat, n;
        for (int i = 0; i < 2; i++) begin
            cv[i] = 0; ca[i] = '0; cwe[i] = 0; cwd[i] = '0; gnt[i] = 0; gd[i] = '0;
            sv[i] = 0; sk[i] = 0; sa[i] = '0; req_cnt[i] = 0;
        end
        for (int a = 0; a < NA; a++) begin
            gold[a] = 32'h1000_0000 + 32'(a) * 32'h0001_0203;
            mem[a] = gold[a]; owner[a] = -1; shr[a] = 2'b00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        for (int c = 0; c < 2; c++) begin
            chk(cr[c] == 1'b1, "R1", "ready after reset", 32'(cr[c]), 32'd1);
            chk(cdone[c] == 1'b0 && qv[c] == 1'b0 && sack[c] == 1'b0, "R1",
                "outputs idle after reset", {cdone[c], qv[c], sack[c]}, 32'd0);
        end

        // R1 R4: cold loads miss; R2: reloads hit.
        for (int a = 0; a < 16; a++) ld(0, a, 1, "R4");
        for (int a = 0; a < 16; a++) ld(0, a, 0, "R2");

        // R5: store on Shared needs GetM; R3: then hits; R2: load in M hits.
        for (int a = 0; a < 8; a++) st(0, a, 32'hC0DE_0000 + 32'(a), 1, "R5");
        for (int a = 0; a < 8; a++) st(0, a, 32'hBEEF_0000 + 32'(a), 0, "R3");
        for (int a = 0; a < 8; a++) ld(0, a, 0, "R2");
        st(0, 12, 32'h5555_000C, 1, "R5");

        // R10: dirty victim is written back, clean victim is dropped.
        ld(0, 16, 1, "R10");
        chk(last_wbv[0] == 1'b1, "R10", "dirty victim wb valid", 32'(last_wbv[0]), 32'd1);
        chk(last_wba[0] == 6'd0, "R10", "victim address", 32'(last_wba[0]), 32'd0);
        chk(last_wbd[0] == 32'hBEEF_0000, "R10", "victim data", last_wbd[0], 32'hBEEF_0000);
        ld(0, 24, 1, "R10");
        chk(last_wbv[0] == 1'b0, "R10", "clean victim no wb", 32'(last_wbv[0]), 32'd0);
        ld(0, 0, 1, "R10");

        // R8 R12: other core reads a Modified line via downgrade.
        ld(1, 1, 1, "R12");
        ld(0, 1, 0, "R8");
        st(0, 1, 32'hA1A1_0001, 1, "R8");
        ld(1, 1, 1, "R7");
        ld(1, 1, 0, "R2");
        st(0, 1, 32'hA2A2_0001, 1, "R12");
        ld(1, 1, 1, "R12");

        // R9: foreign-tag snoops leave the resident line untouched.
        snoop(0, 1'b0, 34, d);
        chk(d == gold[2], "R9", "foreign snoop ack data", d, gold[2]);
        st(0, 2, 32'h0202_0202, 0, "R9");
        snoop(0, 1'b1, 50, d);
        st(0, 2, 32'h0303_0303, 0, "R9");

        // R8: matching downgrade keeps read permission only.
        snoop(0, 1'b1, 2, d);
        chk(d == 32'h0303_0303, "R8", "downgrade data", d, 32'h0303_0303);
        mem[2] = d; owner[2] = -1; shr[2][0] = 1'b1;
        ld(0, 2, 0, "R8");
        st(0, 2, 32'h0404_0404, 1, "R8");

        // R7: matching invalidate drops the line.
        snoop(0, 1'b0, 3, d);
        chk(d == gold[3], "R7", "invalidate data", d, gold[3]);
        mem[3] = d; owner[3] = -1; shr[3] = 2'b00;
        ld(0, 3, 1, "R7");

        // R6: slow grant keeps the core stalled.
        gnt_delay = 5;
        do_op(0, 45, 1'b0, 32'd0, rd, lat, n);
        chk(lat >= 6, "R6", "stall through slow grant", 32'(lat), 32'd6);
        chk(rd == gold[45], "R6", "slow grant data", rd, gold[45]);
        gnt_delay = 0;

        // R12: both cores run at once on disjoint lines, then share one.
        fork
            begin
                for (int i = 0; i < 8; i++) st(0, 48 + i, 32'h7000_0000 + 32'(i), 1, "R12");
                for (int i = 0; i < 8; i++) ld(0, 48 + i, 0, "R12");
            end
            begin
                for (int i = 8; i < 16; i++) st(1, 48 + i, 32'h7100_0000 + 32'(i), 1, "R12");
                for (int i = 8; i < 16; i++) ld(1, 48 + i, 0, "R12");
            end
        join
        fork
            ld(0, 40, 1, "R12");
            ld(1, 40, 1, "R12");
        join
        fork
            ld(0, 40, 0, "R2");
            ld(1, 40, 0, "R2");
        join

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            vectors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule